// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a multi-cycle processor datapath, built as a small microprogram instead of a hand-coded state machine. A 4-bit micro-address register selects one of ten 18-bit control words held as constants. The fields of the selected word drive the datapath control lines directly, so every output is a decode of a registered value and moves only at a clock edge.

The low two bits of each word say where the micro-address goes next. It can return to the fetch word, jump through one of two opcode-indexed lookup tables, or step to the following word. Fetch (word 0) and decode (word 1) run for every instruction. The first table then picks the completion sequence for the instruction class. The second table separates loads from stores after the shared address calculation. Named words are: FETCH (0), DECODE (1), ADDR (2), LD_MEM (3), LD_WB (4), ST_MEM (5), RT_EXE (6), RT_WB (7), BRANCH (8) and JUMP (9). Named transitions are: FETCH→DECODE by step; DECODE→ADDR/RT_EXE/BRANCH/JUMP/FETCH by table one; ADDR→LD_MEM/ST_MEM/FETCH by table two; LD_MEM→LD_WB and RT_EXE→RT_WB by step; LD_WB, ST_MEM, RT_WB, BRANCH and JUMP→FETCH by return.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `upc_out` is 0 and the outputs show the FETCH word. Reset is synchronous and also aborts a sequence in progress.
- R2: Each word's 16 control bits are, from MSB (alu_op 2, alu_src_a 1, alu_src_b 2, {reg_write,mem_to_reg,reg_dst}, {mem_read,mem_write,addr_sel,ir_load}, {pc_load,pc_load_cond,pc_sel[1:0]}), with the sequencing code in word bits 1:0. The values are: FETCH 00_0_01_000_1001_1000, DECODE 00_0_11_000_0000_0000, ADDR 00_1_10_000_0000_0000, LD_MEM 00_0_00_000_1010_0000, LD_WB 00_0_00_110_0000_0000, ST_MEM 00_0_00_000_0110_0000, RT_EXE 10_1_00_000_0000_0000, RT_WB 00_0_00_101_0000_0000, BRANCH 01_1_00_000_0000_0101, JUMP 00_0_00_000_0000_1010. `mem_read` and `mem_write` are never high together.
- R3: Sequencing code 3 (step) makes the next micro-address the current one plus 1. FETCH, LD_MEM and RT_EXE use it.
- R4: Sequencing code 0 (return) makes the next micro-address 0. LD_WB, ST_MEM, RT_WB, BRANCH and JUMP use it.
- R5: Sequencing code 1 (DECODE) looks up table one by opcode. The mapping is 0x23 and 0x2B→2, 0x00→6, 0x04→8, 0x02→9.
- R6: Sequencing code 2 (ADDR) looks up table two by opcode. The mapping is 0x23→3 and 0x2B→5.
- R7: Any opcode absent from a table's mapping yields micro-address 0 in that table.
- R8: The opcode is consulted only at the edge that leaves DECODE or ADDR. A changed opcode in any other word has no effect on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode of the instruction being executed |
| upc_out | output | 4 | Current micro-address |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 by function field |
| alu_src_a | output | 1 | ALU operand A: 0 program counter, 1 register A |
| alu_src_b | output | 2 | ALU operand B: 00 register B, 01 four, 10 immediate, 11 immediate shifted by 2 |
| reg_write | output | 1 | Register file write enable |
| mem_to_reg | output | 1 | Register write data from memory data register |
| reg_dst | output | 1 | Destination register from rd field |
| mem_read | output | 1 | Memory read |
| mem_write | output | 1 | Memory write |
| addr_sel | output | 1 | Memory address from ALU result register |
| ir_load | output | 1 | Load instruction register |
| pc_load | output | 1 | Unconditional program counter write |
| pc_load_cond | output | 1 | Program counter write when ALU zero |
| pc_sel | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |

## Verification
A corrupted micro-address or table entry shows at the ports one clock edge later: `upc_out` leaves the expected path, and the control bus shows a word that does not belong to the instruction. Once the path is wrong it stays wrong until the next return to FETCH. The bench therefore compares the address and all 16 control bits at every cycle of each instruction class. It also changes the opcode between the two lookups and during non-dispatch words to expose lookups taken at the wrong time.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UPC_W   = 4;
    localparam int OP_W    = 6;
    localparam int ALU_W   = 2;
    localparam int SRCB_W  = 2;
    localparam int REGC_W  = 3;
    localparam int MEMC_W  = 4;
    localparam int PCC_W   = 4;
    localparam int SEQ_W   = 2;
    localparam int WORD_W  = ALU_W + 1 + SRCB_W + REGC_W + MEMC_W + PCC_W + SEQ_W;
    localparam int CTRL_W  = WORD_W - SEQ_W;

    typedef enum logic [UPC_W-1:0] {
        MA_FETCH  = 4'd0,
        MA_DECODE = 4'd1,
        MA_ADDR   = 4'd2,
        MA_LDMEM  = 4'd3,
        MA_LDWB   = 4'd4,
        MA_STMEM  = 4'd5,
        MA_RTEXE  = 4'd6,
        MA_RTWB   = 4'd7,
        MA_BRANCH = 4'd8,
        MA_JUMP   = 4'd9
    } ustate_e;

    typedef enum logic [SEQ_W-1:0] {
        SQ_RETURN = 2'd0,
        SQ_TABLE1 = 2'd1,
        SQ_TABLE2 = 2'd2,
        SQ_STEP   = 2'd3
    } seq_e;

    typedef struct packed {
        logic [ALU_W-1:0]  alu;
        logic              src_a;
        logic [SRCB_W-1:0] src_b;
        logic [REGC_W-1:0] regc;
        logic [MEMC_W-1:0] memc;
        logic [PCC_W-1:0]  pcc;
        seq_e              seq;
    } uword_t;

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  ustate_e addr,
    output uword_t  word
);
    always_comb begin
        unique case (addr)
            MA_FETCH:  word = '{alu: 2'b00, src_a: 1'b0, src_b: 2'b01, regc: 3'b000,
                               memc: 4'b1001, pcc: 4'b1000, seq: SQ_STEP};
            MA_DECODE: word = '{alu: 2'b00, src_a: 1'b0, src_b: 2'b11, regc: 3'b000,
                               memc: 4'b0000, pcc: 4'b0000, seq: SQ_TABLE1};
            MA_ADDR:   word = '{alu: 2'b00, src_a: 1'b1, src_b: 2'b10, regc: 3'b000,
                               memc: 4'b0000, pcc: 4'b0000, seq: SQ_TABLE2};
            MA_LDMEM:  word = '{alu: 2'b00, src_a: 1'b0, src_b: 2'b00, regc: 3'b000,
                               memc: 4'b1010, pcc: 4'b0000, seq: SQ_STEP};
            MA_LDWB:   word = '{alu: 2'b00, src_a: 1'b0, src_b: 2'b00, regc: 3'b110,
                               memc: 4'b0000, pcc: 4'b0000, seq: SQ_RETURN};
            MA_STMEM:  word = '{alu: 2'b00, src_a: 1'b0, src_b: 2'b00, regc: 3'b000,
                               memc: 4'b0110, pcc: 4'b0000, seq: SQ_RETURN};
            MA_RTEXE:  word = '{alu: 2'b10, src_a: 1'b1, src_b: 2'b00, regc: 3'b000,
                               memc: 4'b0000, pcc: 4'b0000, seq: SQ_STEP};
            MA_RTWB:   word = '{alu: 2'b00, src_a: 1'b0, src_b: 2'b00, regc: 3'b101,
                               memc: 4'b0000, pcc: 4'b0000, seq: SQ_RETURN};
            MA_BRANCH: word = '{alu: 2'b01, src_a: 1'b1, src_b: 2'b00, regc: 3'b000,
                               memc: 4'b0000, pcc: 4'b0101, seq: SQ_RETURN};
            MA_JUMP:   word = '{alu: 2'b00, src_a: 1'b0, src_b: 2'b00, regc: 3'b000,
                               memc: 4'b0000, pcc: 4'b1010, seq: SQ_RETURN};
            default:   word = '{alu: 2'b00, src_a: 1'b0, src_b: 2'b00, regc: 3'b000,
                               memc: 4'b0000, pcc: 4'b0000, seq: SQ_RETURN};
        endcase
    end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int              TABLE_ID = 1,
    parameter logic [OP_W-1:0] OP_LOAD  = 6'h23,
    parameter logic [OP_W-1:0] OP_STORE = 6'h2B,
    parameter logic [OP_W-1:0] OP_ALU   = 6'h00,
    parameter logic [OP_W-1:0] OP_BR    = 6'h04,
    parameter logic [OP_W-1:0] OP_JMP   = 6'h02
) (
    input  logic [OP_W-1:0] opcode,
    output ustate_e         target
);
    generate
        if (TABLE_ID == 1) begin : g_class_table
            always_comb begin
                unique case (opcode)
                    OP_LOAD, OP_STORE: target = MA_ADDR;
                    OP_ALU:            target = MA_RTEXE;
                    OP_BR:             target = MA_BRANCH;
                    OP_JMP:            target = MA_JUMP;
                    default:           target = MA_FETCH;
                endcase
            end
        end else begin : g_mem_table
            always_comb begin
                unique case (opcode)
                    OP_LOAD:  target = MA_LDMEM;
                    OP_STORE: target = MA_STMEM;
                    default:  target = MA_FETCH;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  ustate_e cur,
    input  seq_e    seq,
    input  ustate_e disp1,
    input  ustate_e disp2,
    output ustate_e nxt
);
    always_comb begin
        unique case (seq)
            SQ_RETURN: nxt = MA_FETCH;
            SQ_TABLE1: nxt = disp1;
            SQ_TABLE2: nxt = disp2;
            SQ_STEP:   nxt = ustate_e'(cur + 4'd1);
            default:   nxt = MA_FETCH;
        endcase
    end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter logic [OP_W-1:0] OP_LOAD  = 6'h23,
    parameter logic [OP_W-1:0] OP_STORE = 6'h2B,
    parameter logic [OP_W-1:0] OP_ALU   = 6'h00,
    parameter logic [OP_W-1:0] OP_BR    = 6'h04,
    parameter logic [OP_W-1:0] OP_JMP   = 6'h02
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  opcode,
    output logic [UPC_W-1:0] upc_out,
    output logic [1:0]       alu_op,
    output logic             alu_src_a,
    output logic [1:0]       alu_src_b,
    output logic             reg_write,
    output logic             mem_to_reg,
    output logic             reg_dst,
    output logic             mem_read,
    output logic             mem_write,
    output logic             addr_sel,
    output logic             ir_load,
    output logic             pc_load,
    output logic             pc_load_cond,
    output logic [1:0]       pc_sel
);
    ustate_e upc, upc_nxt, t1, t2;
    uword_t  word;

    useq_store u_store (.addr(upc), .word(word));

    useq_dispatch #(.TABLE_ID(1), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
                    .OP_ALU(OP_ALU), .OP_BR(OP_BR), .OP_JMP(OP_JMP))
        u_tab1 (.opcode(opcode), .target(t1));

    useq_dispatch #(.TABLE_ID(2), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
                    .OP_ALU(OP_ALU), .OP_BR(OP_BR), .OP_JMP(OP_JMP))
        u_tab2 (.opcode(opcode), .target(t2));

    useq_next u_next (.cur(upc), .seq(word.seq), .disp1(t1), .disp2(t2), .nxt(upc_nxt));

    // state register
    always_ff @(posedge clk) begin
        if (rst) upc <= MA_FETCH;
        else     upc <= upc_nxt;
    end

    // output decode of the current word
    always_comb begin
        upc_out                            = upc;
        alu_op                             = word.alu;
        alu_src_a                          = word.src_a;
        alu_src_b                          = word.src_b;
        {reg_write, mem_to_reg, reg_dst}   = word.regc;
        {mem_read, mem_write, addr_sel, ir_load} = word.memc;
        {pc_load, pc_load_cond, pc_sel}    = word.pcc;
    end

    seq_e cur_seq;
    assign cur_seq = word.seq;

    assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> upc == MA_FETCH);

    assert_mem_excl_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_read, mem_write}));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cur_seq) == SQ_STEP) |-> upc_out == $past(upc_out) + 4'd1);

    assert_return_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cur_seq) == SQ_RETURN) |-> upc == MA_FETCH);

    assert_table1_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(upc) == MA_DECODE) |->
        upc inside {MA_FETCH, MA_ADDR, MA_RTEXE, MA_BRANCH, MA_JUMP});

    assert_table2_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(upc) == MA_ADDR) |->
        upc inside {MA_FETCH, MA_LDMEM, MA_STMEM});

    assert_range_R7: assert property (@(posedge clk) disable iff (rst)
        upc_out <= 4'd9);
endmodule

// File: tb/sim_useq_ctrl.sv
module sim_useq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic [3:0] upc_out;
    logic [1:0] alu_op, alu_src_b, pc_sel;
    logic alu_src_a, reg_write, mem_to_reg, reg_dst, mem_read, mem_write;
    logic addr_sel, ir_load, pc_load, pc_load_cond;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    useq_ctrl u0 (
        .clk(clk), .rst(rst), .opcode(opcode), .upc_out(upc_out),
        .alu_op(alu_op), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
        .reg_write(reg_write), .mem_to_reg(mem_to_reg), .reg_dst(reg_dst),
        .mem_read(mem_read), .mem_write(mem_write), .addr_sel(addr_sel),
        .ir_load(ir_load), .pc_load(pc_load), .pc_load_cond(pc_load_cond),
        .pc_sel(pc_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] exp_word(int a);
        case (a)
            0: return 16'b00_0_01_000_1001_1000;
            1: return 16'b00_0_11_000_0000_0000;
            2: return 16'b00_1_10_000_0000_0000;
            3: return 16'b00_0_00_000_1010_0000;
            4: return 16'b00_0_00_110_0000_0000;
            5: return 16'b00_0_00_000_0110_0000;
            6: return 16'b10_1_00_000_0000_0000;
            7: return 16'b00_0_00_101_0000_0000;
            8: return 16'b01_1_00_000_0000_0101;
            9: return 16'b00_0_00_000_0000_1010;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic check_at(string req, int addr);
        logic [15:0] bus;
        bus = {alu_op, alu_src_a, alu_src_b, reg_write, mem_to_reg, reg_dst,
               mem_read, mem_write, addr_sel, ir_load, pc_load, pc_load_cond, pc_sel};
        chk(req, 32'(upc_out), 32'(addr));
        chk("R2", 32'(bus), 32'(exp_word(addr)));
    endtask

    // starts and ends on a negedge with upc at 0
    task automatic run_instr(string req, logic [5:0] op, int n, int path[5]);
        opcode = op;
        check_at(req, path[0]);
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            check_at(req, path[i]);
        end
        @(negedge clk);
        check_at("R4", 0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_at("R1", 0);
        end
        rst = 1'b0;
        check_at("R1", 0);
    endtask

    task automatic t_classes();
        run_instr("R5_R6_R3", 6'h23, 5, '{0, 1, 2, 3, 4});
        run_instr("R5_R6", 6'h2B, 4, '{0, 1, 2, 5, 0});
        run_instr("R5_R3", 6'h00, 4, '{0, 1, 6, 7, 0});
        run_instr("R5", 6'h04, 3, '{0, 1, 8, 0, 0});
        run_instr("R5", 6'h02, 3, '{0, 1, 9, 0, 0});
    endtask

    task automatic t_undefined();
        run_instr("R7", 6'h3F, 2, '{0, 1, 0, 0, 0});
        run_instr("R7", 6'h11, 2, '{0, 1, 0, 0, 0});
        // table two with an opcode it does not map
        opcode = 6'h23;
        check_at("R7", 0);
        @(negedge clk); check_at("R7", 1);
        @(negedge clk); check_at("R7", 2);
        opcode = 6'h00;
        @(negedge clk); check_at("R7", 0);
    endtask

    task automatic t_ignore();
        opcode = 6'h23;
        @(negedge clk); check_at("R8", 1);
        @(negedge clk); check_at("R8", 2);
        @(negedge clk); check_at("R8", 3);
        opcode = 6'h02;
        @(negedge clk); check_at("R8", 4);
        @(negedge clk); check_at("R8", 0);
        opcode = 6'h00;
        @(negedge clk); check_at("R8", 1);
        @(negedge clk); check_at("R8", 6);
        opcode = 6'h2B;
        @(negedge clk); check_at("R8", 7);
        @(negedge clk); check_at("R8", 0);
    endtask

    task automatic t_reset_midway();
        opcode = 6'h23;
        @(negedge clk); check_at("R1", 1);
        @(negedge clk); check_at("R1", 2);
        @(negedge clk); check_at("R1", 3);
        rst = 1'b1;
        @(negedge clk); check_at("R1", 0);
        rst = 1'b0;
        check_at("R1", 0);
        @(negedge clk); check_at("R3", 1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_classes();
        t_undefined();
        t_ignore();
        t_reset_midway();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule